// File: doc/BRIEF.md
# Ternary-Handshake Pipeline Latch Stage

This block is a clocked, synthesizable model of one stage of a delay-insensitive pipeline. Each data wire carries one of three levels: a spacer level that carries no data, plus a low level and a high level. The request is not a separate line. It is the change of every data wire from spacer to a valid level. An N-wire channel therefore needs only N data wires plus one acknowledge wire running back. Each level is encoded on two binary bits.

When every lane of the input channel carries a valid level and the stage is empty, the stage captures the channel. Once the captured value sits on its output, it raises `full`. The sender treats `full` as its acknowledge and returns its wires to spacer. The stage keeps the captured value until a rising edge on `clear`, which is the `full` of the next stage. On that edge it drops back to spacer and lowers `full`. Stages chain into a shift register. Each stage's `full` feeds the previous stage's `clear`, and its output feeds the next stage's input.

A sticky error flag records input behaviour that breaks the handshake rules. It does not change the data path.

Top module: `trilevel_stage`

## Requirements
- R1: When `rst_n` is low at a rising clock edge (synchronous, active low), every output lane becomes spacer, `full` goes low and `proto_err` goes low.
- R2: Lane k of `in_sym`/`out_sym` sits in bits [2k+1:2k], encoded as 2'b00 = spacer, 2'b01 = low, 2'b10 = high, 2'b11 = invalid. An empty, armed stage whose input lanes are all low or high copies `in_sym` onto `out_sym` at the next rising edge.
- R3: While any input lane is spacer or invalid, no capture takes place, `out_sym` stays all spacer and `full` stays low.
- R4: `full` rises exactly one edge after `out_sym` first becomes non-spacer, and `full` is never high while `out_sym` is all spacer.
- R5: While `full` is high and no release occurs, `out_sym` does not change, whatever `in_sym` does.
- R6: A rising edge of `clear` seen while `full` is high sets `out_sym` to all spacer and `full` low at that clock edge. Holding `clear` high has no further effect, and a `clear` rise while `full` is low has no effect.
- R7: After a capture, a new capture needs the input to have been seen all spacer at some edge first. A value left on the input across a release is not captured again.
- R8: If the next value is already waiting when the release happens, `out_sym` is spacer for exactly one cycle and then shows the new value.
- R9: A direct change of any lane between low and high from one edge to the next sets `proto_err`.
- R10: The invalid code 2'b11 on any input lane sets `proto_err`.
- R11: While `full` is high and the input has not yet been all spacer since the capture, a lane moving from spacer to low or high sets `proto_err`.
- R12: `proto_err` stays high until reset, one edge after the offending input, and setting it changes neither `out_sym` nor `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sym | input | 2*LANES | Input channel, two bits per ternary lane |
| clear | input | 1 | Release request, the next stage's `full` |
| out_sym | output | 2*LANES | Held output channel, two bits per lane |
| full | output | 1 | Acknowledge to the sender: output holds data |
| proto_err | output | 1 | Sticky handshake-violation flag |

## Verification
The hardest case to reach from the ports is the window in which the stage is full and the sender has returned only some lanes to spacer. A lane that rises again there is illegal, while the same rise after the full return is legal. The stimulus captures a word, sends half the lanes back to spacer, and raises one of them again before the others return. A second scenario lets the sender complete its return and present the next word while `full` is high, which shows that no error is raised. That scenario also exercises the single-cycle spacer gap at release.

// File: rtl/trilevel_pkg.sv
package trilevel_pkg;

  typedef enum logic [1:0] {
    TRI_SPACER = 2'b00,
    TRI_LOW    = 2'b01,
    TRI_HIGH   = 2'b10,
    TRI_BAD    = 2'b11
  } tri_sym_e;

  // A lane carries data when it holds the low or the high level.
  function automatic logic sym_is_data(input logic [1:0] s);
    return (s == TRI_LOW) || (s == TRI_HIGH);
  endfunction

  function automatic logic sym_is_spacer(input logic [1:0] s);
    return s == TRI_SPACER;
  endfunction

  function automatic logic sym_is_bad(input logic [1:0] s);
    return s == TRI_BAD;
  endfunction

  // Direct change between the two data levels with no spacer between.
  function automatic logic sym_is_flip(input logic [1:0] prev, input logic [1:0] cur);
    return sym_is_data(prev) && sym_is_data(cur) && (prev != cur);
  endfunction

  // Spacer-to-data move on a lane.
  function automatic logic sym_is_rise(input logic [1:0] prev, input logic [1:0] cur);
    return sym_is_spacer(prev) && sym_is_data(cur);
  endfunction

endpackage

// File: rtl/trilevel_lane_watch.sv
module trilevel_lane_watch
  import trilevel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sym_i,
  input  logic       guard_i,
  output logic       is_data_o,
  output logic       is_spacer_o,
  output logic       bad_o,
  output logic       flip_o,
  output logic       late_rise_o
);

  logic [1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= TRI_SPACER;
    else        prev_q <= sym_i;
  end

  always_comb begin
    is_data_o   = sym_is_data(sym_i);
    is_spacer_o = sym_is_spacer(sym_i);
    bad_o       = sym_is_bad(sym_i);
    flip_o      = sym_is_flip(prev_q, sym_i);
    late_rise_o = guard_i && sym_is_rise(prev_q, sym_i);
  end

endmodule

// File: rtl/trilevel_hold.sv
module trilevel_hold
  import trilevel_pkg::*;
#(
  parameter int LANES = 4,
  localparam int W = 2 * LANES
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_sym_i,
  input  logic         all_data_i,
  input  logic         all_spacer_i,
  input  logic         full_i,
  input  logic         release_i,
  output logic [W-1:0] out_sym_o,
  output logic         busy_o,
  output logic         armed_o,
  output logic         capture_o
);

  logic [W-1:0] hold_q;
  logic         armed_q;

  assign busy_o    = |hold_q;
  assign armed_o   = armed_q;
  assign capture_o = armed_q && all_data_i && !busy_o && !full_i;
  assign out_sym_o = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (release_i) begin
      hold_q <= '0;
    end else if (capture_o) begin
      hold_q <= in_sym_i;
    end
  end

  // The stage re-arms only after the input has been all spacer.
  always_ff @(posedge clk) begin
    if (!rst_n)            armed_q <= 1'b0;
    else if (capture_o)    armed_q <= 1'b0;
    else if (all_spacer_i) armed_q <= 1'b1;
  end

endmodule

// File: rtl/trilevel_full_engine.sv
module trilevel_full_engine (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic busy_i,
  output logic full_o,
  output logic release_o
);

  logic clear_q;
  logic full_q;

  assign release_o = clear_i && !clear_q && full_q;
  assign full_o    = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) clear_q <= 1'b0;
    else        clear_q <= clear_i;
  end

  // Completion detection: full follows a non-spacer output.
  always_ff @(posedge clk) begin
    if (!rst_n)         full_q <= 1'b0;
    else if (release_o) full_q <= 1'b0;
    else if (busy_i)    full_q <= 1'b1;
  end

endmodule

// File: rtl/trilevel_stage.sv
module trilevel_stage
  import trilevel_pkg::*;
#(
  parameter int LANES = 4,
  localparam int W = 2 * LANES
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_sym,
  input  logic         clear,
  output logic [W-1:0] out_sym,
  output logic         full,
  output logic         proto_err
);

  logic [LANES-1:0] lane_data;
  logic [LANES-1:0] lane_spacer;
  logic [LANES-1:0] lane_bad;
  logic [LANES-1:0] lane_flip;
  logic [LANES-1:0] lane_late;

  logic all_data_w;
  logic all_spacer_w;
  logic busy_w;
  logic armed_w;
  logic capture_w;
  logic release_w;
  logic guard_w;
  logic err_now_w;
  logic err_q;

  assign guard_w = full && !armed_w;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    trilevel_lane_watch u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_i       (in_sym[2*k +: 2]),
      .guard_i     (guard_w),
      .is_data_o   (lane_data[k]),
      .is_spacer_o (lane_spacer[k]),
      .bad_o       (lane_bad[k]),
      .flip_o      (lane_flip[k]),
      .late_rise_o (lane_late[k])
    );
  end

  assign all_data_w   = &lane_data;
  assign all_spacer_w = &lane_spacer;
  assign err_now_w    = (|lane_bad) || (|lane_flip) || (|lane_late);

  trilevel_hold #(.LANES(LANES)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_sym_i     (in_sym),
    .all_data_i   (all_data_w),
    .all_spacer_i (all_spacer_w),
    .full_i       (full),
    .release_i    (release_w),
    .out_sym_o    (out_sym),
    .busy_o       (busy_w),
    .armed_o      (armed_w),
    .capture_o    (capture_w)
  );

  trilevel_full_engine u_full (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear),
    .busy_i    (busy_w),
    .full_o    (full),
    .release_o (release_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (err_now_w) err_q <= 1'b1;
  end

  assign proto_err = err_q;

endmodule

// File: rtl/trilevel_stage_chk.sv
module trilevel_stage_chk #(
  parameter int LANES = 4,
  localparam int W = 2 * LANES
)(
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] out_sym,
  input logic         full,
  input logic         proto_err,
  input logic         release_w,
  input logic         capture_w,
  input logic [LANES-1:0] lane_bad
);

  a_r4_full_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(out_sym) != '0);

  a_r4_no_full_on_spacer: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> out_sym != '0);

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !release_w) |=> $stable(out_sym));

  a_r6_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> (out_sym == '0 && !full));

  a_r2_capture_valid: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |=> (out_sym != '0 && !full));

  a_r10_bad_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_bad) |=> proto_err);

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind trilevel_stage trilevel_stage_chk #(.LANES(LANES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_sym   (out_sym),
  .full      (full),
  .proto_err (proto_err),
  .release_w (release_w),
  .capture_w (capture_w),
  .lane_bad  (lane_bad)
);

// File: tb/trilevel_stage_tb_top.sv
module trilevel_stage_tb_top;

  localparam int LANES = 4;
  localparam int W = 2 * LANES;
  // Lane k in bits [2k+1:2k]: 00 spacer, 01 low, 10 high, 11 invalid.
  localparam logic [W-1:0] SP    = 8'h00;
  localparam logic [W-1:0] WA    = 8'b10_01_10_01;
  localparam logic [W-1:0] WB    = 8'b01_10_01_10;
  localparam logic [W-1:0] PART  = 8'b00_01_10_01;
  localparam logic [W-1:0] BADW  = 8'b00_00_00_11;
  localparam logic [W-1:0] HALF  = 8'b00_00_10_01;
  localparam logic [W-1:0] RERAI = 8'b00_10_10_01;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] in_sym = '0;
  logic         clear = 1'b0;
  logic [W-1:0] out_sym;
  logic         full;
  logic         proto_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trilevel_stage #(.LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_sym(in_sym), .clear(clear),
    .out_sym(out_sym), .full(full), .proto_err(proto_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_sym = SP; clear = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out", out_sym, SP);
    check("R1 full", full, 0);
    check("R1 err", proto_err, 0);
  endtask

  task automatic t_capture_release();
    do_reset();
    in_sym = WA; step(1);
    check("R2 captured", out_sym, WA);
    check("R4 full not yet", full, 0);
    step(1);
    check("R4 full one edge later", full, 1);
    in_sym = SP; step(2);
    check("R5 held after spacer", out_sym, WA);
    clear = 1'b1; step(1);
    check("R6 release out", out_sym, SP);
    check("R6 release full", full, 0);
    step(3);
    check("R6 clear held no effect", out_sym, SP);
    check("R6 clear held full", full, 0);
    clear = 1'b0; step(1);
    check("R2 no error", proto_err, 0);
  endtask

  task automatic t_partial();
    do_reset();
    in_sym = PART; step(3);
    check("R3 partial out", out_sym, SP);
    check("R3 partial full", full, 0);
    in_sym = WA; step(1);
    check("R3 completes then capture", out_sym, WA);
  endtask

  task automatic t_waiting_data();
    do_reset();
    in_sym = WA; step(2);
    in_sym = SP; step(1);
    in_sym = WB; step(2);
    check("R5 held while next waits", out_sym, WA);
    check("R5 no error legal next", proto_err, 0);
    clear = 1'b1; step(1);
    check("R8 one spacer cycle", out_sym, SP);
    step(1);
    check("R8 next value", out_sym, WB);
    check("R8 full low yet", full, 0);
    step(1);
    check("R8 full up", full, 1);
    clear = 1'b0; step(1);
  endtask

  task automatic t_no_recapture();
    do_reset();
    in_sym = WA; step(2);
    clear = 1'b1; step(1);
    check("R7 released", out_sym, SP);
    step(3);
    check("R7 no recapture out", out_sym, SP);
    check("R7 no recapture full", full, 0);
    check("R7 no error", proto_err, 0);
    clear = 1'b0;
    in_sym = SP; step(1);
    in_sym = WB; step(1);
    check("R7 capture after spacer", out_sym, WB);
  endtask

  task automatic t_clear_idle();
    do_reset();
    clear = 1'b1; step(2);
    check("R6 idle clear out", out_sym, SP);
    check("R6 idle clear full", full, 0);
    clear = 1'b0;
    in_sym = WA; step(2);
    check("R6 later capture out", out_sym, WA);
    check("R6 later capture full", full, 1);
  endtask

  task automatic t_flip();
    do_reset();
    in_sym = WA; step(1);
    in_sym = WB; step(1);
    check("R9 flip flagged", proto_err, 1);
    check("R12 out unaffected", out_sym, WA);
    step(1);
    check("R12 full unaffected", full, 1);
    in_sym = SP; step(3);
    check("R12 sticky", proto_err, 1);
    do_reset();
    check("R12 cleared by reset", proto_err, 0);
  endtask

  task automatic t_bad();
    do_reset();
    in_sym = BADW; step(1);
    check("R10 invalid flagged", proto_err, 1);
    check("R10 no capture", out_sym, SP);
    check("R10 full low", full, 0);
  endtask

  task automatic t_late_rise();
    do_reset();
    in_sym = WA; step(2);
    in_sym = HALF; step(1);
    check("R11 partial return legal", proto_err, 0);
    in_sym = RERAI; step(1);
    check("R11 early rise flagged", proto_err, 1);
    check("R11 out held", out_sym, WA);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    step(1);
    t_reset();
    t_capture_release();
    t_partial();
    t_waiting_data();
    t_no_recapture();
    t_clear_idle();
    t_flip();
    t_bad();
    t_late_rise();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule